// File: doc/BRIEF.md
# State-Parallel Add-Compare-Select Array

This block is the metric update stage of a 16-state Viterbi decoder for a rate-1/2 convolutional code with constraint length 5. Sixteen add-compare-select cells run side by side, one per trellis state. In each cycle every cell adds a branch metric to each of its two predecessor state metrics, with the sum clamped at the top of the metric range. It then keeps the smaller of the two candidates and reports which predecessor won.

The upstream branch metric calculator supplies four 5-bit branch metrics and a valid strobe. When the strobe is high, the sixteen new 8-bit metrics and the 16-bit decision vector are loaded into one register bank. On the next cycle that bank feeds both the cells and the path memory. The loop from metric register through one cell and back to the register is the only timing path. Reset places the trellis in the all-zero encoder state.

Top module: `acs_array`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register is loaded with metric 0 for state 0, metric 255 for every other state, and an all-zero decision vector.
- R2: At a rising edge where `valid_i` is low, `sm_o` and `dec_o` keep their values whatever `bm_i` carries.
- R3: New state j (state number = bits of `sm_o[8j+7:8j]`) has two predecessors. The even one is p = 2j mod 16 and the odd one is p + 1. Its new metric is the smaller of the two saturated sums of predecessor metric plus branch metric.
- R4: The branch metric for a transition is chosen as follows. Take the predecessor state s (4 bits) and the input bit u = j[3], and form the 5-bit vector r = {u, s}. Compute c0 = XOR of (r AND 10011b) and c1 = XOR of (r AND 11101b). The transition uses BM number 2*c0 + c1, and BM number d sits at `bm_i[5d+4:5d]`.
- R5: A candidate sum above 255 is clamped to 255, and metrics never wrap.
- R6: When the two candidates are equal, the even predecessor wins and the decision bit is 0.
- R7: Decision bit `dec_o[j]` is 1 exactly when the odd predecessor gave the strictly smaller candidate for state j. It is registered on the same edge as the metric of state j.
- R8: With `valid_i` high at a rising edge, the outputs show the result computed from the pre-edge `sm_o` and `bm_i` right after that edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Branch metrics valid; enables the update |
| bm_i | input | 20 | Four packed 5-bit branch metrics, BM d at bits 5d+4:5d |
| sm_o | output | 128 | Registered state metrics, state j at bits 8j+7:8j |
| dec_o | output | 16 | Registered path-select bits, bit j for state j |

## Verification
A wrong predecessor wiring, a wrong branch metric choice or a wrong tie rule shows up on `dec_o` and `sm_o` at the first strobed edge after the fault is reached. The bench therefore compares every state after every update. A metric error then spreads through the trellis: each bad state feeds two successors on the next update, so within four updates most states differ. Clamping faults only appear once sums pass 255, so a run with full-scale branch metrics is included.

// File: rtl/acs_pkg.sv
// Package acs_pkg
// Shared constants and constant functions for the state-parallel ACS array.
// Assumes a rate-1/2 code whose encoder shifts new input bits into the
// most significant state position.
package acs_pkg;
    localparam int CL     = 5;                 // constraint length
    localparam int NS     = 1 << (CL - 1);     // trellis states
    localparam int NBM    = 4;                 // branch metrics per cycle
    localparam int MW     = 8;                 // state metric width
    localparam int BW     = 5;                 // branch metric width
    localparam logic [CL-1:0] GEN_A = 5'o23;   // first generator taps
    localparam logic [CL-1:0] GEN_B = 5'o35;   // second generator taps

    // Branch metric number for predecessor s entered with input bit u.
    function automatic int branch_sel(input int s, input int u);
        logic [CL-1:0] r;
        logic          c0;
        logic          c1;
        r  = CL'((u << (CL - 1)) | (s % NS));
        c0 = ^(r & GEN_A);
        c1 = ^(r & GEN_B);
        return (c0 ? 2 : 0) + (c1 ? 1 : 0);
    endfunction
endpackage

// File: rtl/acs_sat_add.sv
// Module acs_sat_add
// Adds an unsigned branch metric to an unsigned state metric and clamps
// the result to the all-ones value when the sum leaves the metric range.
// Assumes BMW <= SMW.
module acs_sat_add #(
    parameter int SMW = 8,
    parameter int BMW = 5
) (
    input  logic [SMW-1:0] sm_i,
    input  logic [BMW-1:0] bm_i,
    output logic [SMW-1:0] sum_o
);
    localparam int PADW = SMW + 1 - BMW;

    logic [SMW:0] wide;

    // Full-width sum with carry, then clamp on carry out.
    always_comb begin
        wide  = {1'b0, sm_i} + {{PADW{1'b0}}, bm_i};
        sum_o = wide[SMW] ? {SMW{1'b1}} : wide[SMW-1:0];
    end
endmodule

// File: rtl/acs_cell.sv
// Module acs_cell
// One add-compare-select unit: two saturating adds, a compare and a select.
// The even (upper) candidate wins ties; sel_o = 1 means the odd
// (lower) candidate was strictly smaller.
module acs_cell #(
    parameter int SMW = 8,
    parameter int BMW = 5
) (
    input  logic [SMW-1:0] sm_up_i,
    input  logic [SMW-1:0] sm_lo_i,
    input  logic [BMW-1:0] bm_up_i,
    input  logic [BMW-1:0] bm_lo_i,
    output logic [SMW-1:0] nsm_o,
    output logic           sel_o
);
    logic [SMW-1:0] cand_up;
    logic [SMW-1:0] cand_lo;

    acs_sat_add #(.SMW(SMW), .BMW(BMW)) add_up_i (
        .sm_i  (sm_up_i),
        .bm_i  (bm_up_i),
        .sum_o (cand_up)
    );

    acs_sat_add #(.SMW(SMW), .BMW(BMW)) add_lo_i (
        .sm_i  (sm_lo_i),
        .bm_i  (bm_lo_i),
        .sum_o (cand_lo)
    );

    // Compare candidates and forward the survivor.
    always_comb begin
        sel_o = (cand_up > cand_lo);
        nsm_o = sel_o ? cand_lo : cand_up;
    end
endmodule

// File: rtl/acs_metric_reg.sv
// Module acs_metric_reg
// Pipeline register for all state metrics and decision bits.
// Synchronous active-low reset loads state 0 with zero and every other
// state with the all-ones metric, so decoding starts in state 0.
module acs_metric_reg #(
    parameter int NST = 16,
    parameter int SMW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [NST*SMW-1:0] sm_d_i,
    input  logic [NST-1:0]     dec_d_i,
    output logic [NST*SMW-1:0] sm_q_o,
    output logic [NST-1:0]     dec_q_o
);
    genvar g;
    generate
        for (g = 0; g < NST; g++) begin : g_state
            localparam logic [SMW-1:0] INIT = (g == 0) ? '0 : '1;

            // Hold or load one state metric and its decision bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sm_q_o[g*SMW +: SMW] <= INIT;
                    dec_q_o[g]           <= 1'b0;
                end else if (en_i) begin
                    sm_q_o[g*SMW +: SMW] <= sm_d_i[g*SMW +: SMW];
                    dec_q_o[g]           <= dec_d_i[g];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/acs_array.sv
// Module acs_array
// State-parallel add-compare-select stage: one ACS cell per trellis state,
// wired by the butterfly pattern (state j fed by 2j mod NS and 2j mod NS + 1),
// followed by the metric/decision register. Branch metric choice per
// transition is a constant derived from the generator pair in acs_pkg.
module acs_array
    import acs_pkg::*;
#(
    parameter int SMW = acs_pkg::MW,
    parameter int BMW = acs_pkg::BW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic [NBM*BMW-1:0]  bm_i,
    output logic [NS*SMW-1:0]   sm_o,
    output logic [NS-1:0]       dec_o
);
    localparam int HALF = NS / 2;

    logic [NS*SMW-1:0] nsm;
    logic [NS-1:0]     sel;

    genvar j;
    generate
        for (j = 0; j < NS; j++) begin : g_acs
            localparam int P_UP   = (2 * j) % NS;
            localparam int P_LO   = P_UP + 1;
            localparam int U_BIT  = j / HALF;
            localparam int IX_UP  = branch_sel(P_UP, U_BIT);
            localparam int IX_LO  = branch_sel(P_LO, U_BIT);

            acs_cell #(.SMW(SMW), .BMW(BMW)) cell_i (
                .sm_up_i (sm_o[P_UP*SMW +: SMW]),
                .sm_lo_i (sm_o[P_LO*SMW +: SMW]),
                .bm_up_i (bm_i[IX_UP*BMW +: BMW]),
                .bm_lo_i (bm_i[IX_LO*BMW +: BMW]),
                .nsm_o   (nsm[j*SMW +: SMW]),
                .sel_o   (sel[j])
            );
        end
    endgenerate

    acs_metric_reg #(.NST(NS), .SMW(SMW)) reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (valid_i),
        .sm_d_i  (nsm),
        .dec_d_i (sel),
        .sm_q_o  (sm_o),
        .dec_q_o (dec_o)
    );
endmodule

// File: rtl/acs_array_chk.sv
// Module acs_array_chk
// Property checker bound to acs_array; watches only its ports.
module acs_array_chk
    import acs_pkg::*;
#(
    parameter int SMW = acs_pkg::MW,
    parameter int BMW = acs_pkg::BW
) (
    input logic               clk,
    input logic               rst_n,
    input logic               valid_i,
    input logic [NBM*BMW-1:0] bm_i,
    input logic [NS*SMW-1:0]  sm_o,
    input logic [NS-1:0]      dec_o
);
    logic [SMW-1:0] cur [NS];

    // Unpack the metric bus per state for readability.
    always_comb begin
        for (int k = 0; k < NS; k++) cur[k] = sm_o[k*SMW +: SMW];
    end

    // R1
    reset_zero_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cur[0] == '0 && dec_o == '0));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(sm_o) && $stable(dec_o)));

    genvar j;
    generate
        for (j = 0; j < NS; j++) begin : g_st
            localparam int P_UP = (2 * j) % NS;
            localparam int P_LO = P_UP + 1;

            if (j > 0) begin : g_rst
                // R1
                reset_max_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !$past(rst_n) |-> (cur[j] == '1));
            end

            // R3
            metric_not_below_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
                valid_i |=> (cur[j] >= $past(cur[P_UP]) || cur[j] >= $past(cur[P_LO])));

            // R5
            saturated_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_i && cur[P_UP] == '1 && cur[P_LO] == '1) |=> (cur[j] == '1));

            // R6
            tie_picks_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_i && cur[P_UP] == '1 && cur[P_LO] == '1) |=> !dec_o[j]);
        end
    endgenerate
endmodule

bind acs_array acs_array_chk #(.SMW(SMW), .BMW(BMW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .bm_i    (bm_i),
    .sm_o    (sm_o),
    .dec_o   (dec_o)
);

// File: tb/acs_array_tb_top.sv
// Directed bench for acs_array with an independent behavioural model.
module acs_array_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 16;
    localparam int MW  = 8;
    localparam int BW  = 5;
    localparam int MAXM = 255;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid_i = 1'b0;
    logic [4*BW-1:0] bm_i = '0;
    logic [NS*MW-1:0] sm_o;
    logic [NS-1:0]   dec_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int exp_sm [NS];
    logic [NS-1:0] exp_dec;

    acs_array dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
        .bm_i(bm_i), .sm_o(sm_o), .dec_o(dec_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run is a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int parity5(input int v);
        int p = 0;
        for (int b = 0; b < 5; b++) p ^= (v >> b) & 1;
        return p;
    endfunction

    // R4: BM number from {u, s} and the two tap sets.
    function automatic int bm_num(input int s, input int u);
        int r = u * 16 + s;
        return 2 * parity5(r & 'h13) + parity5(r & 'h1D);
    endfunction

    function automatic int clamp(input int v);
        return (v > MAXM) ? MAXM : v;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NS; k++) exp_sm[k] = (k == 0) ? 0 : MAXM;
        exp_dec = '0;
    endtask

    task automatic model_step(input int b0, input int b1, input int b2, input int b3);
        int bm [4];
        int nxt [NS];
        bm[0] = b0; bm[1] = b1; bm[2] = b2; bm[3] = b3;
        for (int k = 0; k < NS; k++) begin
            int pu = (2 * k) % NS;
            int pl = pu + 1;
            int u  = k / 8;
            int cu = clamp(exp_sm[pu] + bm[bm_num(pu, u)]);
            int cl = clamp(exp_sm[pl] + bm[bm_num(pl, u)]);
            exp_dec[k] = (cl < cu);
            nxt[k] = (cl < cu) ? cl : cu;
        end
        for (int k = 0; k < NS; k++) exp_sm[k] = nxt[k];
    endtask

    task automatic check_all(input string tag);
        int mism = 0;
        int first = -1;
        for (int k = 0; k < NS; k++) begin
            if (int'(sm_o[k*MW +: MW]) != exp_sm[k]) begin
                mism++;
                if (first < 0) first = k;
            end
        end
        total++;
        if (mism != 0) begin
            bad++;
            $display("FAIL %s metric state %0d: actual=%0d expected=%0d", tag, first,
                     sm_o[first*MW +: MW], exp_sm[first]);
        end
        total++;
        if (dec_o !== exp_dec) begin
            bad++;
            $display("FAIL %s decisions: actual=%h expected=%h", tag, dec_o, exp_dec);
        end
    endtask

    task automatic check_val(input string tag, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // One clock with given strobe and metrics; sample at the following negedge.
    task automatic drive(input logic v, input int b0, input int b1, input int b2, input int b3);
        @(negedge clk);
        valid_i = v;
        bm_i = {BW'(b3), BW'(b2), BW'(b1), BW'(b0)};
        @(negedge clk);
        if (v) model_step(b0, b1, b2, b3);
        valid_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        valid_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic t_reset();
        do_reset();
        check_all("R1 reset state");
        check_val("R1 state0 metric", int'(sm_o[MW-1:0]), 0);
        check_val("R1 state15 metric", int'(sm_o[15*MW +: MW]), MAXM);
    endtask

    task automatic t_hold();
        do_reset();
        drive(1'b1, 3, 7, 1, 9);
        for (int n = 0; n < 3; n++) drive(1'b0, 31, 0, 17, 5);
        check_all("R2 idle hold");
    endtask

    task automatic t_first_step();
        do_reset();
        drive(1'b1, 1, 2, 3, 4);
        check_all("R8 first step");
        check_val("R4 state0 uses BM0", int'(sm_o[0 +: MW]), 1);
        check_val("R4 state8 uses BM3", int'(sm_o[8*MW +: MW]), 4);
        check_val("R6 tie decisions zero", int'(dec_o), 0);
        drive(1'b1, 5, 1, 6, 2);
        check_all("R3 second step");
    endtask

    task automatic t_saturate();
        do_reset();
        for (int n = 0; n < 8; n++) drive(1'b1, 31, 31, 31, 31);
        check_val("R5 state0 below clamp", int'(sm_o[0 +: MW]), 248);
        check_all("R5 before clamp");
        drive(1'b1, 31, 31, 31, 31);
        check_all("R5 clamp step");
        check_val("R5 state0 clamped", int'(sm_o[0 +: MW]), MAXM);
    endtask

    task automatic t_random();
        int ones = 0;
        do_reset();
        for (int n = 0; n < 300; n++) begin
            logic v = ($urandom_range(3, 0) != 0);
            drive(v, $urandom_range(31, 0), $urandom_range(31, 0),
                  $urandom_range(31, 0), $urandom_range(31, 0));
            if (n % 50 == 49) do_reset();
            check_all("R3 R7 random");
            ones += $countones(exp_dec);
        end
        total++;
        if (ones == 0) begin
            bad++;
            $display("FAIL R7 odd predecessor never chosen: actual=0 expected>0");
        end
    endtask

    initial begin
        t_reset();
        t_hold();
        t_first_step();
        t_saturate();
        t_random();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule